// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block gathers a parameterised set of level-sensitive interrupt sources and hands them to a parameterised set of targets, such as processor cores. Each source has one priority level, and that level is shared by every target. Each target has its own enable mask and its own threshold. On every cycle the block works out, for each target, the best pending source that the target has enabled. The target's request line is raised when that source's priority is strictly above the target's threshold.

Software drives the block through one word-addressed register port. It sets priorities, enables and thresholds, and it can inspect the pending bits. To take an interrupt, a target reads its claim/complete register. That read returns the ID of the winning source and locks it. When the service is finished, software writes the same ID back to the same register. ID 0 is reserved and means that there is nothing to service.

The register map uses these derived bases, with NW = ceil(NSRC/32):
- Priorities sit at words 0..NSRC-1.
- Pending words begin at PEND_BASE = NSRC.
- Enables begin at IE_BASE = PEND_BASE+NW.
- Thresholds begin at THR_BASE = IE_BASE+NW*NTGT.
- Claim/complete registers begin at CC_BASE = THR_BASE+NTGT.

Read data is registered and appears on the cycle after the read strobe. It is held until the next read.

Top module: `plic_core`

## Requirements
- R1: After reset, every request line is 0. Every priority, enable, threshold and pending word reads 0, and a claim read returns 0.
- R2: A priority write to word i (i < NSRC) keeps only the low PRIO_W bits of the write data, and that single value serves all targets.
- R3: The enable bit for source s of target t is word IE_BASE + NW*t + (s>>5), bit s mod 32.
- R4: A target is notified only when its best enabled pending source has a priority strictly greater than its threshold. A priority equal to the threshold does not notify, and a priority of 0 never notifies.
- R5: A read of CC_BASE+t returns the ID of the highest-priority source that target t has enabled and that is pending above the threshold. Among equal priorities, the lowest ID wins.
- R6: A claim clears that source's pending bit. The source cannot become pending again until its ID is written to a claim/complete register; after that, a source still held high becomes pending again on the next cycle.
- R7: After a claim, the next claim offers the remaining lower-priority pending sources. A higher-priority source that becomes pending in between is offered first.
- R8: A claim read with no eligible source returns 0 and changes no state.
- R9: A completion write whose ID is 0, is not below NSRC, or is not currently claimed is ignored.
- R10: Source 0 never becomes pending, whatever its input does.
- R11: Pending word w (at PEND_BASE+w) bit b shows source 32*w+b. These words are read-only, and writes to them are ignored.
- R12: A request line follows pending, enable, priority and threshold state one cycle after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Level-sensitive interrupt sources; bit 0 is unused |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a read of a claim register claims |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, valid the cycle after rd_en_i |
| irq_o | output | NTGT | Per-target registered request lines |

## Verification
The hardest state to reach is a source that is claimed while its input stays high, with other sources of higher, lower and equal priority arriving around the claim. Only that case shows the blocking, the re-arm on completion and the preemption by a newcomer. The stimulus first builds a directed tie-and-threshold scenario. It then runs a long random phase in which source levels persist for several cycles. In that phase completions mostly return the most recently claimed ID, so claims, blocked re-assertions and completions interleave often. Every read and every request line is compared with a bench model of pending, claimed, enable, priority and threshold state.

// File: rtl/plic_pkg.sv
// Package: shared helpers for the interrupt controller core.
// Assumes nothing beyond integer parameters being positive.
package plic_pkg;
    localparam int WORD_W = 32;

    // Number of 32-bit words needed to hold n one-bit flags.
    function automatic int words32(input int n);
        return (n + WORD_W - 1) / WORD_W;
    endfunction
endpackage

// File: rtl/plic_gateway.sv
// Module: plic_gateway
// Holds the pending and claimed flags of every source. A high source that
// is not claimed becomes pending. A claim clears pending and marks the
// source claimed. A completion of a claimed source releases it.
// Assumes claim and completion never arrive in the same cycle, and that
// the IDs presented to it are in range.
module plic_gateway #(
    parameter int NSRC = 40,
    parameter int IDW  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            claim_vld_i,
    input  logic [IDW-1:0]  claim_id_i,
    input  logic            cmpl_vld_i,
    input  logic [IDW-1:0]  cmpl_id_i,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] pend_q, pend_n;
    logic [NSRC-1:0] busy_q, busy_n;

    // Next-state of the pending and claimed flags.
    always_comb begin
        pend_n    = pend_q | (src_i & ~busy_q);
        pend_n[0] = 1'b0;
        busy_n    = busy_q;
        if (cmpl_vld_i && busy_q[int'(cmpl_id_i)]) begin
            busy_n[int'(cmpl_id_i)] = 1'b0;
        end
        if (claim_vld_i) begin
            pend_n[int'(claim_id_i)] = 1'b0;
            busy_n[int'(claim_id_i)] = 1'b1;
        end
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            busy_q <= '0;
        end else begin
            pend_q <= pend_n;
            busy_q <= busy_n;
        end
    end

    assign pend_o = pend_q;

    // R6
    blocked_stays_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & $past(busy_q & ~pend_q)) == '0));
    // R5
    claim_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_vld_i |-> pend_q[int'(claim_id_i)]);
    // R6
    claim_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_vld_i |=> busy_q[int'($past(claim_id_i))]);
    // R9
    stray_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_vld_i && !busy_q[int'(cmpl_id_i)] && !claim_vld_i) |=> busy_q == $past(busy_q));
endmodule

// File: rtl/plic_target_sel.sv
// Module: plic_target_sel
// Selection for one target. It finds the highest-priority enabled pending
// source (the lowest ID wins a tie) and registers a request when that
// priority exceeds the target's threshold.
// Assumes source 0 is never to be selected.
module plic_target_sel #(
    parameter int NSRC   = 40,
    parameter int PRIO_W = 3,
    parameter int IDW    = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              pend_i,
    input  logic [NSRC-1:0]              ie_i,
    input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [IDW-1:0]               best_id_o,
    output logic                         best_ok_o,
    output logic                         irq_o
);
    logic [PRIO_W-1:0] best_p;
    logic              irq_q;

    // Ascending scan: a strict compare keeps the lowest ID on a tie.
    always_comb begin
        best_p    = '0;
        best_id_o = '0;
        for (int i = 1; i < NSRC; i++) begin
            if (pend_i[i] && ie_i[i] && (prio_i[i] > best_p)) begin
                best_p    = prio_i[i];
                best_id_o = IDW'(i);
            end
        end
        best_ok_o = (best_p > thr_i);
    end

    // Registered request line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= best_ok_o;
    end

    assign irq_o = irq_q;

    // R12
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(pend_i & ie_i) != '0);
    // R4
    irq_top_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(thr_i) != '1);
endmodule

// File: rtl/plic_regs.sv
// Module: plic_regs
// Register file and access decode. It holds priorities, enables and
// thresholds, and it turns claim reads and completion writes into strobes
// for the gateway.
// Assumes at most one access per cycle from the register port.
module plic_regs #(
    parameter int NSRC   = 40,
    parameter int NTGT   = 2,
    parameter int PRIO_W = 3,
    parameter int IDW    = 6,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic                          rd_en_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [31:0]                   wdata_i,
    output logic [31:0]                   rdata_o,
    input  logic [NSRC-1:0]               pend_i,
    input  logic [NTGT-1:0][IDW-1:0]      best_id_i,
    input  logic [NTGT-1:0]               best_ok_i,
    output logic [NSRC-1:0][PRIO_W-1:0]   prio_o,
    output logic [NTGT-1:0][NSRC-1:0]     ie_o,
    output logic [NTGT-1:0][PRIO_W-1:0]   thr_o,
    output logic                          claim_vld_o,
    output logic [IDW-1:0]                claim_id_o,
    output logic                          cmpl_vld_o,
    output logic [IDW-1:0]                cmpl_id_o
);
    localparam int NW        = plic_pkg::words32(NSRC);
    localparam int PEND_BASE = NSRC;
    localparam int IE_BASE   = PEND_BASE + NW;
    localparam int THR_BASE  = IE_BASE + NW * NTGT;
    localparam int CC_BASE   = THR_BASE + NTGT;

    logic [NSRC-1:0][PRIO_W-1:0]   prio_q;
    logic [NTGT*NW-1:0][31:0]      ie_q;
    logic [NTGT-1:0][PRIO_W-1:0]   thr_q;
    logic [NW*32-1:0]              pend_pad;
    logic [31:0]                   rd_n, rdata_q;
    int                            a;

    assign a = int'(addr_i);

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            ie_q   <= '0;
            thr_q  <= '0;
        end else if (wr_en_i) begin
            for (int i = 0; i < NSRC; i++)
                if (a == i) prio_q[i] <= wdata_i[PRIO_W-1:0];
            for (int k = 0; k < NTGT * NW; k++)
                if (a == IE_BASE + k) ie_q[k] <= wdata_i;
            for (int t = 0; t < NTGT; t++)
                if (a == THR_BASE + t) thr_q[t] <= wdata_i[PRIO_W-1:0];
        end
    end

    // Claim and completion strobes from accesses to the claim registers.
    always_comb begin
        claim_vld_o = 1'b0;
        claim_id_o  = '0;
        cmpl_vld_o  = 1'b0;
        cmpl_id_o   = wdata_i[IDW-1:0];
        for (int t = 0; t < NTGT; t++) begin
            if (a == CC_BASE + t) begin
                if (rd_en_i && best_ok_i[t]) begin
                    claim_vld_o = 1'b1;
                    claim_id_o  = best_id_i[t];
                end
                if (wr_en_i && (wdata_i != 32'd0) && (wdata_i < 32'(NSRC)))
                    cmpl_vld_o = 1'b1;
            end
        end
    end

    // Read data selection.
    always_comb begin
        pend_pad             = '0;
        pend_pad[NSRC-1:0]   = pend_i;
        rd_n                 = '0;
        for (int i = 0; i < NSRC; i++)
            if (a == i) rd_n = 32'(prio_q[i]);
        for (int w = 0; w < NW; w++)
            if (a == PEND_BASE + w) rd_n = pend_pad[w*32 +: 32];
        for (int k = 0; k < NTGT * NW; k++)
            if (a == IE_BASE + k) rd_n = ie_q[k];
        for (int t = 0; t < NTGT; t++) begin
            if (a == THR_BASE + t) rd_n = 32'(thr_q[t]);
            if (a == CC_BASE + t)  rd_n = best_ok_i[t] ? 32'(best_id_i[t]) : 32'd0;
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_n;
    end

    // Enable words unpacked into one mask per target.
    always_comb begin
        for (int t = 0; t < NTGT; t++)
            for (int s = 0; s < NSRC; s++)
                ie_o[t][s] = ie_q[t*NW + s/32][s%32];
    end

    assign prio_o  = prio_q;
    assign thr_o   = thr_q;
    assign rdata_o = rdata_q;

    // R8
    claim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_vld_o |-> claim_id_o != '0);
    // R2
    prio_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && a < NSRC) |=> rdata_o < 32'(1 << PRIO_W));
endmodule

// File: rtl/plic_core.sv
// Module: plic_core
// Top of the interrupt controller core. It joins the register file, the
// source gateway and one selector per target.
// Assumes the register port issues at most one access per cycle.
module plic_core #(
    parameter int NSRC   = 40,
    parameter int NTGT   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic [NTGT-1:0]   irq_o
);
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0]               pend;
    logic [NSRC-1:0][PRIO_W-1:0]   prio;
    logic [NTGT-1:0][NSRC-1:0]     ie;
    logic [NTGT-1:0][PRIO_W-1:0]   thr;
    logic [NTGT-1:0][IDW-1:0]      best_id;
    logic [NTGT-1:0]               best_ok;
    logic                          claim_vld, cmpl_vld;
    logic [IDW-1:0]                claim_id, cmpl_id;

    plic_regs #(.NSRC(NSRC), .NTGT(NTGT), .PRIO_W(PRIO_W), .IDW(IDW), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .pend_i(pend), .best_id_i(best_id), .best_ok_i(best_ok),
        .prio_o(prio), .ie_o(ie), .thr_o(thr),
        .claim_vld_o(claim_vld), .claim_id_o(claim_id),
        .cmpl_vld_o(cmpl_vld), .cmpl_id_o(cmpl_id)
    );

    plic_gateway #(.NSRC(NSRC), .IDW(IDW)) u_gateway (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .claim_vld_i(claim_vld), .claim_id_i(claim_id),
        .cmpl_vld_i(cmpl_vld), .cmpl_id_i(cmpl_id), .pend_o(pend)
    );

    for (genvar t = 0; t < NTGT; t++) begin : g_tgt
        plic_target_sel #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_sel (
            .clk(clk), .rst_n(rst_n), .pend_i(pend), .ie_i(ie[t]),
            .prio_i(prio), .thr_i(thr[t]),
            .best_id_o(best_id[t]), .best_ok_o(best_ok[t]), .irq_o(irq_o[t])
        );
    end
endmodule

// File: tb/plic_core_bench.sv
module plic_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 40, NTGT = 2, PRIO_W = 3, ADDR_W = 8;
    localparam int NW = (NSRC + 31) / 32;
    localparam int PEND_BASE = NSRC;
    localparam int IE_BASE = PEND_BASE + NW;
    localparam int THR_BASE = IE_BASE + NW * NTGT;
    localparam int CC_BASE = THR_BASE + NTGT;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [NTGT-1:0] irq_o;

    plic_core #(.NSRC(NSRC), .NTGT(NTGT), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_plic_core (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit m_pend[NSRC], m_busy[NSRC];
    int m_prio[NSRC], m_thr[NTGT];
    logic [31:0] m_ie[NW*NTGT];
    logic [NSRC-1:0] src_v = '0;
    int last_claim = 0;

    function automatic bit m_ie_bit(int t, int s);
        logic [31:0] w = m_ie[t*NW + s/32];
        return w[s%32];
    endfunction

    // Best eligible ID for target t, or 0 when nothing exceeds the threshold.
    function automatic int m_best(int t);
        int bp = 0, bi = 0;
        for (int i = 1; i < NSRC; i++)
            if (m_pend[i] && m_ie_bit(t, i) && m_prio[i] > bp) begin bp = m_prio[i]; bi = i; end
        return (bp > m_thr[t]) ? bi : 0;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] v = '0;
        if (a < NSRC) v = 32'(m_prio[a]);
        else if (a < IE_BASE) begin
            for (int b = 0; b < 32; b++)
                if ((a-PEND_BASE)*32 + b < NSRC) v[b] = m_pend[(a-PEND_BASE)*32 + b];
        end
        else if (a < THR_BASE) v = m_ie[a-IE_BASE];
        else if (a < CC_BASE) v = 32'(m_thr[a-THR_BASE]);
        else if (a < CC_BASE + NTGT) v = 32'(m_best(a-CC_BASE));
        return v;
    endfunction

    function automatic string tag_of(int a);
        if (a < NSRC) return "R2";
        if (a < IE_BASE) return "R11";
        if (a < THR_BASE) return "R3";
        if (a < CC_BASE) return "R4";
        return "R5";
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock cycle: drive, predict, check, then advance the model.
    task automatic cyc(bit we, bit re, int a, logic [31:0] wd);
        logic [NTGT-1:0] exp_irq;
        logic [31:0] exp_rd;
        int cl;
        @(negedge clk);
        wr_en_i = we; rd_en_i = re; addr_i = ADDR_W'(a); wdata_i = wd; src_i = src_v;
        for (int t = 0; t < NTGT; t++) exp_irq[t] = (m_best(t) != 0);
        exp_rd = m_read(a);
        cl = (re && a >= CC_BASE && a < CC_BASE + NTGT) ? m_best(a-CC_BASE) : 0;
        @(posedge clk); #1;
        chk(irq_o === exp_irq, "R12/R4 irq", 32'(irq_o), 32'(exp_irq));
        if (re) chk(rdata_o === exp_rd, tag_of(a), rdata_o, exp_rd);
        for (int i = 1; i < NSRC; i++)
            if (src_v[i] && !m_busy[i]) m_pend[i] = 1;
        if (we) begin
            if (a < NSRC) m_prio[a] = int'(wd[PRIO_W-1:0]);
            else if (a >= IE_BASE && a < THR_BASE) m_ie[a-IE_BASE] = wd;
            else if (a >= THR_BASE && a < CC_BASE) m_thr[a-THR_BASE] = int'(wd[PRIO_W-1:0]);
            else if (a >= CC_BASE && a < CC_BASE + NTGT && wd != 0 && wd < NSRC && m_busy[wd])
                m_busy[wd] = 0;
        end
        if (cl != 0) begin m_pend[cl] = 0; m_busy[cl] = 1; last_claim = cl; end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, '0);
    endtask

    initial begin
        void'($urandom(32'h1c0de));
        for (int i = 0; i < NSRC; i++) begin m_pend[i] = 0; m_busy[i] = 0; m_prio[i] = 0; end
        for (int k = 0; k < NW*NTGT; k++) m_ie[k] = '0;
        for (int t = 0; t < NTGT; t++) m_thr[t] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state of all register groups and the claim registers
        src_v = '1;
        cyc(0, 1, 5, '0); cyc(0, 1, PEND_BASE, '0); cyc(0, 1, IE_BASE + NW, '0);
        cyc(0, 1, THR_BASE + 1, '0); cyc(0, 1, CC_BASE, '0);
        src_v = '0; idle(2);
        // R2: only the low bits of a priority survive
        cyc(1, 0, 3, 32'hff); cyc(0, 1, 3, '0);
        cyc(1, 0, 5, 32'h0f); cyc(1, 0, 0, 32'h7);
        // R3: enable sources 3, 5, 0 and 33 of target 0 (bit 33 lives in word 1)
        cyc(1, 0, IE_BASE, 32'h29); cyc(1, 0, IE_BASE + 1, 32'h2); cyc(0, 1, IE_BASE + 1, '0);
        // R4: priority equal to threshold does not notify
        cyc(1, 0, THR_BASE, 32'd7);
        src_v[3] = 1; src_v[5] = 1; src_v[0] = 1; idle(3);
        // R11/R10: pending word 0 shows 3 and 5, never 0; writes to it are ignored
        cyc(1, 0, PEND_BASE, 32'h0); cyc(0, 1, PEND_BASE, '0);
        cyc(1, 0, THR_BASE, 32'd6); idle(2);
        // R5: tie at priority 7 goes to ID 3; R7: then 5 is offered
        cyc(0, 1, CC_BASE, '0); idle(1);
        // R7: a higher newcomer preempts a lower one
        cyc(1, 0, 33, 32'd7); cyc(1, 0, 5, 32'd6); cyc(1, 0, THR_BASE, 32'd0);
        src_v[33] = 1; idle(2);
        cyc(0, 1, CC_BASE, '0); cyc(0, 1, CC_BASE, '0);
        // R8: no eligible source returns 0
        cyc(0, 1, CC_BASE, '0); cyc(0, 1, CC_BASE + 1, '0);
        // R9: completions of unclaimed, zero and out-of-range IDs are ignored
        cyc(1, 0, CC_BASE, 32'd9); cyc(1, 0, CC_BASE, 32'd0); cyc(1, 0, CC_BASE, 32'd60);
        idle(2); cyc(0, 1, PEND_BASE, '0);
        // R6: sources held high stay blocked until completed, then re-arm
        idle(3); cyc(0, 1, PEND_BASE, '0);
        cyc(1, 0, CC_BASE, 32'd3); idle(1); cyc(0, 1, PEND_BASE, '0);
        // Random phase
        for (int it = 0; it < 6000; it++) begin
            int op = $urandom_range(0, 9);
            if ($urandom_range(0, 7) == 0) src_v[$urandom_range(0, NSRC-1)] ^= 1'b1;
            case (op)
                0: cyc(1, 0, $urandom_range(0, NSRC-1), $urandom);
                1: cyc(1, 0, IE_BASE + $urandom_range(0, NW*NTGT-1), $urandom);
                2: cyc(1, 0, THR_BASE + $urandom_range(0, NTGT-1), $urandom_range(0, 7));
                3, 4: cyc(0, 1, CC_BASE + $urandom_range(0, NTGT-1), '0);
                5: cyc(1, 0, CC_BASE + $urandom_range(0, NTGT-1),
                       ($urandom_range(0, 3) != 0) ? 32'(last_claim) : 32'($urandom_range(0, 63)));
                6: cyc(0, 1, $urandom_range(0, CC_BASE - 1), '0);
                default: cyc(0, 0, 0, '0);
            endcase
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule